// File: doc/BRIEF.md
# Fractional Bit-Clock Divider

This block derives a serial-port bit clock from a fast timer-base clock. The base clock is about 66.66 MHz, twice the oscillator. The divisor has three fields: an integer part A, a numerator term B and a denominator term C. Each output period lasts either A or A+1 base cycles. An accumulator decides which periods are stretched, and it spreads the long periods evenly across each group of C+1 periods. In the default mode the average period is A + (B+1)/(C+1) base cycles. An alternate mode uses a numerator of B instead of B+1. The design aims for an exact average rate and accepts one base cycle of jitter on any single period. The supported output rates run from roughly 65 kbit/s to more than 20 Mbit/s, which puts A between a few units and about one thousand.

Software loads a new divisor word with a one-cycle load pulse. The new word takes effect at the next period boundary. While enabled, the block drives a roughly square clock and a one-cycle strobe at the start of every period. Dropping the enable stops and clears the block.

Top module: `frac_bitclk_div`

## Requirements
- R1: After reset, and on every cycle in which `enable` is low, `bitClk` and `bitStrobe` are both 0.
- R2: In default mode (`altMode`=0) the numerator is n=B+1 and the denominator is d=C+1. Period k (k=1,2,...) counted from a restart lasts A + (floor(k*n/d) - floor((k-1)*n/d)) base cycles.
- R3: In alternate mode (`altMode`=1) the numerator is n=B, and the period lengths follow the same rule as R2. With B=0, every period lasts exactly A cycles.
- R4: A numerator n greater than d is treated as n=d, so every period lasts A+1 cycles.
- R5: An A field of 0 or 1 is treated as 2, so no period is shorter than 2 cycles.
- R6: In each period of length L, `bitClk` is high for the first floor(L/2) cycles and low for the rest.
- R7: `bitStrobe` is high only in the first cycle of each period. The first cycle with `enable` high is always a period start.
- R8: A divisor word captured by `loadDiv` (fields `divA`, `divB`, `divC`, `altMode`) does not change the period in progress. It takes effect at the next period start, and that period counts as k=1.
- R9: When `enable` goes low and then high again, the sequence restarts at k=1 with the last word applied.
- R10: Over the first d periods after a restart, the total length equals d*A + n, with A and n as adjusted by R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer-base clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider when high; clears it when low |
| loadDiv | input | 1 | One-cycle pulse that captures the divisor word |
| divA | input | A_W | Integer part A |
| divB | input | F_W | Numerator term B |
| divC | input | F_W | Denominator term C |
| altMode | input | 1 | Selects numerator B instead of B+1 |
| bitClk | output | 1 | Divided bit clock |
| bitStrobe | output | 1 | One-cycle pulse at each period start |

## Verification
The bench starts with directed divisor words, each of which separates one rule from its neighbours:
- B=C=0 in both modes shows whether the plus-one offset is present.
- A=4, B=2, C=4 tests the even spread of stretched periods.
- A B larger than C tests the clamp on the numerator.
- A of 0 and 1 tests the minimum period.

Random words then vary all fields and the mode. Each measured period is compared with the floor formula, and the sum over each group of C+1 periods is compared with the exact total. A load in the middle of a period and a disable/re-enable show whether the period in progress survives a load and whether the accumulator restarts from zero.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  // Strobes sent from the period control to the divisor datapath
  typedef struct packed {
    logic periodStart;  // first cycle of an output period
    logic takeNew;      // period start that adopts the pending word
    logic idle;         // divider disabled this cycle
  } divCtl_t;
endpackage

// File: rtl/frac_bitclk_dpath.sv
module frac_bitclk_dpath
  import fbd_pkg::*;
#(
  parameter int A_W = 10,
  parameter int F_W = 8,
  parameter int MIN_A = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadDiv,
  input  logic [A_W-1:0]       divA,
  input  logic [F_W-1:0]       divB,
  input  logic [F_W-1:0]       divC,
  input  logic                 altMode,
  input  divCtl_t              ctl,
  output logic [A_W:0]         curLen
);
  localparam int NUM_W = F_W + 1;
  localparam int LEN_W = A_W + 1;

  logic [A_W-1:0] pendA, actA, selA, aEff;
  logic [F_W-1:0] pendB, actB, selB, pendC, actC, selC;
  logic           pendAlt, actAlt, selAlt;
  logic [NUM_W-1:0] num, numC, den, acc, accBase, sum;
  logic           stretch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA <= '0; pendB <= '0; pendC <= '0; pendAlt <= 1'b0;
      actA  <= '0; actB  <= '0; actC  <= '0; actAlt  <= 1'b0;
    end else begin
      if (loadDiv) begin
        pendA <= divA; pendB <= divB; pendC <= divC; pendAlt <= altMode;
      end
      if (ctl.takeNew) begin
        actA <= pendA; actB <= pendB; actC <= pendC; actAlt <= pendAlt;
      end
    end
  end

  // The word in force for the period that starts this cycle
  always_comb begin
    selA   = ctl.takeNew ? pendA   : actA;
    selB   = ctl.takeNew ? pendB   : actB;
    selC   = ctl.takeNew ? pendC   : actC;
    selAlt = ctl.takeNew ? pendAlt : actAlt;
  end

  // Integer part, with a floor so both phases last at least one cycle
  assign aEff = (selA < A_W'(MIN_A)) ? A_W'(MIN_A) : selA;

  // Numerator (offset chosen by mode) and denominator of the fraction
  always_comb begin
    den = {1'b0, selC} + NUM_W'(1);
    if (selAlt) num = {1'b0, selB};
    else        num = {1'b0, selB} + NUM_W'(1);
    numC = (num > den) ? den : num;
  end

  // acc < den and numC <= den, so the sum stays below 2*den
  assign accBase = ctl.takeNew ? '0 : acc;
  assign sum     = accBase + numC;
  assign stretch = (sum >= den);
  assign curLen  = LEN_W'(aEff) + LEN_W'(stretch);

  always_ff @(posedge clk) begin
    if (!rstN)               acc <= '0;
    else if (ctl.idle)       acc <= '0;
    else if (ctl.periodStart) acc <= stretch ? (sum - den) : sum;
  end

  // Residue stays strictly below the denominator in force (R2)
  assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.takeNew |-> (acc < den));

  // Disabled cycles leave the accumulator empty (R9)
  assert_acc_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> (acc == '0));
endmodule

// File: rtl/frac_bitclk_ctrl.sv
module frac_bitclk_ctrl
  import fbd_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             loadDiv,
  input  logic [LEN_W-1:0] curLen,
  output divCtl_t          ctl,
  output logic             bitClk,
  output logic             bitStrobe
);
  logic [LEN_W-1:0] cnt, lenReg, half;
  logic             pendValid, atStart;

  assign atStart         = enable && (cnt == '0);
  assign ctl.periodStart = atStart;
  assign ctl.takeNew     = atStart && pendValid;
  assign ctl.idle        = !enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      lenReg    <= '0;
      pendValid <= 1'b0;
    end else begin
      if (loadDiv)          pendValid <= 1'b1;
      else if (ctl.takeNew) pendValid <= 1'b0;

      if (!enable) begin
        cnt <= '0;
      end else if (atStart) begin
        cnt    <= LEN_W'(1);
        lenReg <= curLen;
      end else if (cnt == lenReg - LEN_W'(1)) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  assign half      = lenReg >> 1;
  assign bitStrobe = atStart;
  assign bitClk    = enable && (atStart || (cnt < half));

  // Period counter never runs past the latched length (R2)
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (cnt < lenReg));

  // Datapath never requests a period below the minimum (R5)
  assert_len_min_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.periodStart |-> (curLen >= LEN_W'(2)));

  // A disabled cycle returns the counter to the start (R1)
  assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cnt == '0));

  // Strobes are never back to back (R7)
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  // A pending word is consumed at the start it is applied to (R8)
  assert_pend_consumed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeNew && !loadDiv) |=> !pendValid);
endmodule

// File: rtl/frac_bitclk_div.sv
module frac_bitclk_div
  import fbd_pkg::*;
#(
  parameter int A_W = 10,
  parameter int F_W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           loadDiv,
  input  logic [A_W-1:0] divA,
  input  logic [F_W-1:0] divB,
  input  logic [F_W-1:0] divC,
  input  logic           altMode,
  output logic           bitClk,
  output logic           bitStrobe
);
  localparam int LEN_W = A_W + 1;

  divCtl_t          ctl;
  logic [LEN_W-1:0] curLen;

  frac_bitclk_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .loadDiv(loadDiv),
    .curLen(curLen), .ctl(ctl), .bitClk(bitClk), .bitStrobe(bitStrobe)
  );

  frac_bitclk_dpath #(.A_W(A_W), .F_W(F_W)) dpath_i (
    .clk(clk), .rstN(rstN), .loadDiv(loadDiv), .divA(divA), .divB(divB),
    .divC(divC), .altMode(altMode), .ctl(ctl), .curLen(curLen)
  );
endmodule

// File: tb/frac_bitclk_div_tb_top.sv
module frac_bitclk_div_tb_top;
  localparam int A_W = 10;
  localparam int F_W = 8;

  logic clk = 1'b0;
  logic rstN, enable, loadDiv, altMode;
  logic [A_W-1:0] divA;
  logic [F_W-1:0] divB, divC;
  logic bitClk, bitStrobe;
  logic sBit, sStb;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_bitclk_div #(.A_W(A_W), .F_W(F_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .loadDiv(loadDiv),
    .divA(divA), .divB(divB), .divC(divC), .altMode(altMode),
    .bitClk(bitClk), .bitStrobe(bitStrobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample in the middle of the cycle, then step to just after the next edge
  task automatic tick();
    @(negedge clk);
    sBit = bitClk;
    sStb = bitStrobe;
    @(posedge clk);
    #1;
  endtask

  function automatic int effA(int a);
    return (a < 2) ? 2 : a;
  endfunction

  function automatic int effN(int b, int c, int alt);
    int n;
    n = alt ? b : b + 1;
    return (n > c + 1) ? c + 1 : n;
  endfunction

  function automatic int expLen(int a, int b, int c, int alt, int k);
    int n, d;
    n = effN(b, c, alt);
    d = c + 1;
    return effA(a) + ((k * n) / d - ((k - 1) * n) / d);
  endfunction

  task automatic loadWord(int a, int b, int c, int alt);
    divA = A_W'(a); divB = F_W'(b); divC = F_W'(c); altMode = alt[0];
    loadDiv = 1'b1;
    tick();
    loadDiv = 1'b0;
  endtask

  // Measures nPer periods and checks each against the R2/R3 rule.
  // preStarted: the first period's strobe cycle has already been seen.
  task automatic observe(int a, int b, int c, int alt, int nPer, bit preStarted, string req);
    int len, hi, k, total, guard;
    bit started;
    started = preStarted;
    len = preStarted ? 1 : 0;
    hi = preStarted ? 1 : 0;
    k = 0; total = 0; guard = 0;
    while (k < nPer && guard < 50000) begin
      tick();
      guard++;
      if (sStb) begin
        if (started) begin
          k++;
          chk(len == expLen(a, b, c, alt, k), req, len, expLen(a, b, c, alt, k));
          chk(hi == expLen(a, b, c, alt, k) / 2, "R6 high phase", hi, expLen(a, b, c, alt, k) / 2);
          total += len;
          if (k == c + 1)
            chk(total == (c + 1) * effA(a) + effN(b, c, alt), "R10 average", total,
                (c + 1) * effA(a) + effN(b, c, alt));
        end
        chk(sBit == 1'b1, "R7 strobe on clock high", sBit, 1);
        started = 1'b1;
        len = 0; hi = 0;
      end
      if (started) begin
        len++;
        hi += int'(sBit);
      end
    end
    chk(k == nPer, "R7 strobes seen", k, nPer);
  endtask

  task automatic runCfg(int a, int b, int c, int alt, int nPer, string req);
    enable = 1'b0;
    tick();
    loadWord(a, b, c, alt);
    tick();
    enable = 1'b1;
    observe(a, b, c, alt, nPer, 1'b0, req);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int len, ticks;
    rstN = 1'b0; enable = 1'b0; loadDiv = 1'b0; altMode = 1'b0;
    divA = '0; divB = '0; divC = '0;
    #1;
    tick();
    tick();
    chk(sBit == 1'b0 && sStb == 1'b0, "R1 reset", int'({sBit, sStb}), 0);
    rstN = 1'b1;
    tick();
    chk(sBit == 1'b0 && sStb == 1'b0, "R1 after reset", int'({sBit, sStb}), 0);

    // Word loaded while disabled must not start anything
    loadWord(7, 1, 3, 0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(sBit == 1'b0 && sStb == 1'b0, "R1 disabled", int'({sBit, sStb}), 0);
    end

    runCfg(5, 0, 0, 0, 3, "R2 offset present");
    runCfg(5, 0, 0, 1, 3, "R3 offset dropped");
    runCfg(4, 2, 4, 0, 10, "R2 spread");
    runCfg(4, 2, 4, 1, 10, "R3 spread");
    runCfg(3, 9, 2, 0, 6, "R4 clamp");
    runCfg(0, 0, 3, 0, 8, "R5 minimum A=0");
    runCfg(1, 0, 0, 1, 4, "R5 minimum A=1");
    runCfg(2, 5, 6, 0, 7, "R2 A=2");

    // R8: load mid-period, the running period keeps the old length
    runCfg(6, 1, 2, 0, 3, "R2 before load");
    loadWord(9, 3, 4, 1);
    ticks = 0;
    do begin tick(); ticks++; end while (!sStb && ticks < 5000);
    len = 1 + ticks;
    chk(len == expLen(6, 1, 2, 0, 4), "R8 period in progress", len, expLen(6, 1, 2, 0, 4));
    observe(9, 3, 4, 1, 6, 1'b1, "R8 new word from k=1");

    // R9: disable mid-run and re-enable, sequence restarts at k=1
    observe(9, 3, 4, 1, 2, 1'b0, "R9 running");
    enable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(sBit == 1'b0 && sStb == 1'b0, "R1 disabled mid-run", int'({sBit, sStb}), 0);
    end
    enable = 1'b1;
    observe(9, 3, 4, 1, 6, 1'b0, "R9 restart");

    // Random words
    void'($urandom(32'd2718));
    for (int t = 0; t < 30; t++) begin
      int a, b, c, alt;
      a = int'($urandom_range(0, 40));
      c = int'($urandom_range(0, 15));
      b = int'($urandom_range(0, c + 3));
      alt = int'($urandom_range(0, 1));
      runCfg(a, b, c, alt, c + 2, alt ? "R3 random" : "R2 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule